// File: doc/BRIEF.md
# Converter Clock Prescaler Chain

This block derives three timing strobes from one parent clock for an analog-to-digital converter. A main counter divides the parent clock into a converter clock-enable. Two further counters advance only on that enable and produce a coarse 10 µs tick and a slower 1 ms tick, which control software uses for settling and wait intervals. All outputs are pulses one parent cycle wide, so the rest of the chip stays in the parent clock domain.

A single 32-bit configuration word holds the three divide ratios. Each field stores its ratio minus one, so a field of zero means divide by one and the matching strobe stays high. A new word is never applied in the middle of a period. Each counter finishes the period it is counting with the old ratio and picks up the new ratio when it reloads. A build-time option selects a compact layout for faster converters. In that layout the main field is only six bits wide, the 10 µs field moves up, and there is no 1 ms counter.

Top module: `adc_clk_presc`

## Requirements
- R1: After reset every field is zero, so `conv_ce`, `tick_10us` and `tick_1ms` are all high in the first cycle after reset is released.
- R2: In the default layout the main ratio-minus-one field is bits [7:0], the 10 µs field is bits [15:8] and the 1 ms field is bits [23:16]. Bits [31:24] have no effect on any output.
- R3: With main field value M, `conv_ce` pulses once every M+1 parent cycles.
- R4: With 10 µs field value U, `tick_10us` pulses once every U+1 pulses of `conv_ce`, which is (M+1)(U+1) parent cycles, and it is only ever high together with `conv_ce`.
- R5: With 1 ms field value S, `tick_1ms` counts `conv_ce` pulses directly and pulses every (M+1)(S+1) parent cycles, always together with `conv_ce`.
- R6: A field of zero selects divide by one. With main field 0, `conv_ce` is high in every cycle. With both main and 10 µs fields 0, `tick_10us` is high in every cycle.
- R7: A write takes effect only at each counter's next reload. Even a write issued in the same cycle as a pulse leaves the period in progress at its old length, and the new ratio applies from the following period.
- R8: The main field reaches ratio 256 (value 0xFF), giving a `conv_ce` period of 256 cycles.
- R9: With a main ratio above one, each strobe is high for exactly one parent cycle per period.
- R10: In the compact layout the main field is bits [5:0] (ratios 1 to 64) and the 10 µs field is bits [23:16]. Bits [15:6] have no effect, and `tick_1ms` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the divider word |
| cfg_wdata | input | 32 | Divider word, each field holding ratio minus one |
| conv_ce | output | 1 | Converter clock-enable pulse |
| tick_10us | output | 1 | Pulse every 10 µs-field converter periods |
| tick_1ms | output | 1 | Pulse every 1 ms-field converter periods |

## Verification
The bench builds two copies of the block. The first uses the default layout and covers the three cascaded counters, including the full 256 main ratio and the divide-by-one settings. The second sets `COMPACT_LAYOUT` to 1, which brings within reach the six-bit main field, the relocated 10 µs field and the absent 1 ms counter. Reload timing is tested by writing a new main ratio in the very cycle of a `conv_ce` pulse, and the intervals on either side of that write are measured.

// File: rtl/adc_presc_pkg.sv
package adc_presc_pkg;

   localparam int CFG_W = 32;

   function automatic int main_width(bit compact);
      return compact ? 6 : 8;
   endfunction

   function automatic int us_lsb(bit compact);
      return compact ? 16 : 8;
   endfunction

   function automatic int ms_lsb(bit compact);
      return compact ? 0 : 16;
   endfunction

   function automatic bit has_ms(bit compact);
      return !compact;
   endfunction

endpackage

// File: rtl/adc_presc_cfg.sv
module adc_presc_cfg #(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= wdata;
   end
endmodule

// File: rtl/adc_presc_stage.sv
module adc_presc_stage #(
   parameter int RATIO_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               advance,
   input  logic [RATIO_W-1:0] ratio_m1,
   output logic               tick
);
   logic [RATIO_W-1:0] cnt_q;
   logic               at_term;

   generate
      if (RATIO_W < 1 || RATIO_W > 16) begin : g_bad_width
         $error("adc_presc_stage: RATIO_W must be 1..16");
      end
   endgenerate

   assign at_term = (cnt_q == '0);
   assign tick    = advance & at_term;

   // the field is sampled only at terminal count: no shortened period
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (advance) cnt_q <= at_term ? ratio_m1 : cnt_q - 1'b1;
   end
endmodule

// File: rtl/adc_clk_presc.sv
module adc_clk_presc #(
   parameter bit COMPACT_LAYOUT = 1'b0,
   parameter int US_W           = 8,
   parameter int MS_W           = 8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cfg_we,
   input  logic [31:0] cfg_wdata,
   output logic        conv_ce,
   output logic        tick_10us,
   output logic        tick_1ms
);
   import adc_presc_pkg::*;

   localparam int MAIN_W   = main_width(COMPACT_LAYOUT);
   localparam int MAIN_LSB = 0;
   localparam int US_LSB   = us_lsb(COMPACT_LAYOUT);
   localparam int MS_LSB   = ms_lsb(COMPACT_LAYOUT);
   localparam bit HAS_MS   = has_ms(COMPACT_LAYOUT);

   generate
      if (MAIN_LSB + MAIN_W > US_LSB) begin : g_main_overlap
         $error("adc_clk_presc: main field overlaps 10us field");
      end
      if (US_LSB + US_W > CFG_W) begin : g_us_range
         $error("adc_clk_presc: 10us field exceeds register");
      end
      if (HAS_MS && (US_LSB + US_W > MS_LSB || MS_LSB + MS_W > CFG_W)) begin : g_ms_range
         $error("adc_clk_presc: 1ms field placement invalid");
      end
   endgenerate

   logic [CFG_W-1:0]  cfg_q;
   logic [MAIN_W-1:0] main_m1;
   logic [US_W-1:0]   us_m1;

   adc_presc_cfg #(.WIDTH(CFG_W)) u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .wdata (cfg_wdata),
      .q     (cfg_q)
   );

   assign main_m1 = cfg_q[MAIN_LSB +: MAIN_W];
   assign us_m1   = cfg_q[US_LSB +: US_W];

   adc_presc_stage #(.RATIO_W(MAIN_W)) u_main (
      .clk      (clk),
      .rst_n    (rst_n),
      .advance  (1'b1),
      .ratio_m1 (main_m1),
      .tick     (conv_ce)
   );

   adc_presc_stage #(.RATIO_W(US_W)) u_us (
      .clk      (clk),
      .rst_n    (rst_n),
      .advance  (conv_ce),
      .ratio_m1 (us_m1),
      .tick     (tick_10us)
   );

   generate
      if (HAS_MS) begin : g_ms
         logic [MS_W-1:0] ms_m1;
         assign ms_m1 = cfg_q[MS_LSB +: MS_W];
         adc_presc_stage #(.RATIO_W(MS_W)) u_ms (
            .clk      (clk),
            .rst_n    (rst_n),
            .advance  (conv_ce),
            .ratio_m1 (ms_m1),
            .tick     (tick_1ms)
         );
      end else begin : g_no_ms
         assign tick_1ms = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/adc_clk_presc_chk.sv
module adc_clk_presc_chk #(
   parameter int MAIN_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              conv_ce,
   input logic              tick_10us,
   input logic              tick_1ms,
   input logic [MAIN_W-1:0] main_f
);
   // R4
   us_with_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick_10us |-> conv_ce);

   // R5
   ms_with_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick_1ms |-> conv_ce);

   // R3
   ce_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_ce && main_f != '0) |=> !conv_ce);

   // R6
   ce_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_ce && main_f == '0) |=> conv_ce);

   // R9
   us_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_10us && main_f != '0) |=> !tick_10us);
endmodule

bind adc_clk_presc adc_clk_presc_chk #(.MAIN_W(MAIN_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .conv_ce   (conv_ce),
   .tick_10us (tick_10us),
   .tick_1ms  (tick_1ms),
   .main_f    (main_m1)
);

// File: tb/test_adc_clk_presc.sv
`timescale 1ns/1ps
module test_adc_clk_presc;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic        a_we = 1'b0;
   logic [31:0] a_wdata = '0;
   logic        conv_ce, tick_10us, tick_1ms;
   logic        a_ce, a_us, a_ms;
   int          n_chk = 0;
   int          n_bad = 0;

   always #2.5 clk = ~clk;

   adc_clk_presc i_adc_clk_presc (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .conv_ce(conv_ce), .tick_10us(tick_10us), .tick_1ms(tick_1ms));

   adc_clk_presc #(.COMPACT_LAYOUT(1'b1)) i_alt (
      .clk(clk), .rst_n(rst_n), .cfg_we(a_we), .cfg_wdata(a_wdata),
      .conv_ce(a_ce), .tick_10us(a_us), .tick_1ms(a_ms));

   function automatic logic sig(int s);
      case (s)
         0: return conv_ce;
         1: return tick_10us;
         2: return tick_1ms;
         3: return a_ce;
         4: return a_us;
         default: return a_ms;
      endcase
   endfunction

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(logic [31:0] d);
      @(negedge clk); cfg_we = 1'b1; cfg_wdata = d;
      @(negedge clk); cfg_we = 1'b0;
   endtask

   task automatic wr_alt(logic [31:0] d);
      @(negedge clk); a_we = 1'b1; a_wdata = d;
      @(negedge clk); a_we = 1'b0;
   endtask

   task automatic wait_high(int s);
      int g = 0;
      do begin @(negedge clk); g++; end while (!sig(s) && g < 5000);
   endtask

   // discards the first pulse, then measures three full intervals
   task automatic measure(int s, int exp, string req);
      wait_high(s);
      for (int k = 0; k < 3; k++) begin
         int n = 0;
         do begin @(negedge clk); n++; end while (!sig(s) && n < 5000);
         chk(req, n, exp);
      end
   endtask

   task automatic width(int s, string req);
      int n = 0;
      wait_high(s);
      while (sig(s) && n < 5000) begin n++; @(negedge clk); end
      chk(req, n, 1);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R1 conv_ce", conv_ce, 1);
      chk("R1 tick_10us", tick_10us, 1);
      chk("R1 tick_1ms", tick_1ms, 1);
   endtask

   task automatic t_basic();
      wr(32'h0009_0403);
      measure(0, 4, "R3");
      measure(1, 20, "R4");
      measure(2, 40, "R5");
      width(0, "R9 conv_ce");
      width(1, "R9 tick_10us");
      width(2, "R9 tick_1ms");
   endtask

   task automatic t_div1();
      wr(32'h0000_0200);
      measure(0, 1, "R6 conv_ce");
      measure(1, 3, "R6 tick_10us");
      measure(2, 1, "R6 tick_1ms");
      wr(32'h0000_0000);
      measure(1, 1, "R6 tick_10us steady");
   endtask

   task automatic t_upper();
      wr(32'hAB05_0201);
      measure(0, 2, "R2 main");
      measure(1, 6, "R2 10us");
      measure(2, 12, "R2 1ms");
   endtask

   task automatic t_max();
      wr(32'h0002_01FF);
      measure(0, 256, "R8 conv_ce");
      measure(1, 512, "R8 tick_10us");
   endtask

   task automatic t_reload();
      int n;
      wr(32'h0000_0007);
      measure(0, 8, "R7 before");
      wait_high(0);
      cfg_we = 1'b1; cfg_wdata = 32'h0000_0002;
      n = 0;
      do begin
         @(negedge clk); n++;
         if (n == 1) cfg_we = 1'b0;
      end while (!conv_ce && n < 5000);
      chk("R7 period in flight", n, 8);
      n = 0;
      do begin @(negedge clk); n++; end while (!conv_ce && n < 5000);
      chk("R7 next period", n, 3);
   endtask

   task automatic t_alt();
      int hi = 0;
      wr_alt(32'h0004_55C3);
      measure(3, 4, "R10 main");
      measure(4, 20, "R10 10us");
      for (int k = 0; k < 100; k++) begin
         @(negedge clk);
         if (a_ms) hi++;
      end
      chk("R10 no 1ms tick", hi, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      t_reset();
      t_basic();
      t_div1();
      t_upper();
      t_max();
      t_reload();
      t_alt();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule